// File: doc/BRIEF.md
# Cascadable presettable binary counter

This block is a synchronous binary counter made of 4-bit stages that all share one clock. Each stage can be cleared to zero at any moment by an active-low asynchronous clear. It can be preset from a parallel data bus by an active-low synchronous load. It advances by one only when two separate enables are both high. One enable (`cep`) goes to every stage at once. The other (`cet`) enters the lowest stage and ripples upward as a carry.

Each stage drives a combinational terminal-count flag. The flag is high when the stage's carry enable is high and its nibble is all ones. That flag is the carry enable of the stage above, so the stages form a wider counter with look-ahead carry. The terminal count of the top stage is the block's terminal-count output. It can enable a further counter outside the block.

The number of stages is a parameter, so one design serves counters of 4, 8, 12 or more bits.

Top module: `cascnt_top`

## Requirements
- R1: While `clear_n` is low, every bit of `count` is 0. The clear takes effect at once, with no clock edge needed, whatever `load_n`, `cep` and `cet` are doing.
- R2: With `clear_n` high and `load_n` low at a rising edge of `clk`, `count` takes the value of `load_val`, whatever the levels of `cep` and `cet`.
- R3: With `clear_n` and `load_n` high and both `cep` and `cet` high at a rising edge, `count` increases by one as a full 4*N-bit binary number. A lower stage that is all ones carries into the stage above.
- R4: When `count` is all ones and increments, it wraps to all zeros. Each 4-bit stage wraps from 15 to 0.
- R5: With `clear_n` and `load_n` high and either `cep` or `cet` low at a rising edge, `count` keeps its value.
- R6: `tc` is 1 exactly when `cet` is 1 and every bit of `count` is 1. `cep` has no effect on `tc`. `tc` follows a change of `cet` without waiting for a clock edge.
- R7: While `clear_n` is low, `tc` is 0.
- R8: Priority is clear first, then load, then count, then hold. A load with both enables high stores `load_val` and does not increment it.
- R9: After a clear, a load of 12 (0x0C) followed by six counting edges gives a low nibble of 13, 14, 15, 0, 1, 2. At the 15-to-0 step the next nibble goes up by one, so the full value becomes 0x12 for N=2. Once an enable drops, the value stays at 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all stages change on the rising edge |
| clear_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| cep | input | 1 | Parallel count enable, sent to every stage |
| cet | input | 1 | Carry count enable into the lowest stage; also gates `tc` |
| load_val | input | 4*N | Value stored on a load |
| count | output | 4*N | Current counter value |
| tc | output | 1 | Terminal count: `cet` high and `count` all ones |

## Verification
The counting path is tried with the reference sequence from 12. That sequence shows whether the low nibble carries into the next one at the right step, and whether a dropped enable holds the value.

A load of 0xFE followed by counting reaches all ones and then wraps. On the way it separates the case where `tc` is gated by `cet` from the case where it is gated by `cep`. Toggling `cet` between clock edges shows whether `tc` is combinational or registered.

A clear raised in the middle of a cycle, with load and both enables active, tests the priority order and the asynchronous nature of the clear. A long stretch of pseudo-random load, enable and data patterns is compared on every cycle against a behavioural model. It catches wrong enable gating and wrong carries at any nibble boundary.

// File: rtl/cascnt_pkg.sv
package cascnt_pkg;
  localparam int unsigned NIB_W = 4;
  localparam logic [NIB_W-1:0] NIB_MAX = '1;

  // one-step advance of a stage nibble, wrapping after the maximum
  function automatic logic [NIB_W-1:0] nib_next(input logic [NIB_W-1:0] v);
    return v + {{(NIB_W-1){1'b0}}, 1'b1};
  endfunction

  // a nibble at its terminal value
  function automatic logic nib_full(input logic [NIB_W-1:0] v);
    return v == NIB_MAX;
  endfunction
endpackage

// File: rtl/cascnt_stage.sv
module cascnt_stage
  import cascnt_pkg::*;
(
  input  logic             clk,
  input  logic             clear_n,
  input  logic             load_n,
  input  logic             cep,
  input  logic             cet_in,
  input  logic [NIB_W-1:0] d,
  output logic [NIB_W-1:0] q,
  output logic             tc_out
);
  logic [NIB_W-1:0] q_r;
  logic             load_ev;   // parallel load requested this edge
  logic             step_en;   // increment requested this edge
  logic             at_full;

  assign load_ev = ~load_n;
  assign step_en = load_n & cep & cet_in;
  assign at_full = nib_full(q_r);

  always_ff @(posedge clk or negedge clear_n) begin
    if (!clear_n)     q_r <= '0;
    else if (load_ev) q_r <= d;
    else if (step_en) q_r <= nib_next(q_r);
  end

  assign q      = q_r;
  assign tc_out = clear_n & cet_in & at_full;

  // R1: clear dominates at every edge
  always @(posedge clk) begin
    if (!clear_n) p_clear_zero_r1: assert (q_r == '0);
  end

  // R2 / R8: load wins over the enables
  p_load_r2: assert property (@(posedge clk) disable iff (!clear_n)
    load_ev |=> q_r == $past(d));

  // R3 / R4: increment wraps within the nibble
  p_count_r3: assert property (@(posedge clk) disable iff (!clear_n)
    step_en |=> q_r == nib_next($past(q_r)));

  // R5: hold when an enable is low
  p_hold_r5: assert property (@(posedge clk) disable iff (!clear_n)
    (load_n && !(cep && cet_in)) |=> $stable(q_r));
endmodule

// File: rtl/cascnt_top.sv
module cascnt_top
  import cascnt_pkg::*;
#(
  parameter int unsigned N = 2
) (
  input  logic             clk,
  input  logic             clear_n,
  input  logic             load_n,
  input  logic             cep,
  input  logic             cet,
  input  logic [4*N-1:0]   load_val,
  output logic [4*N-1:0]   count,
  output logic             tc
);
  localparam int unsigned W = NIB_W * N;

  logic [N:0] carry_chain;  // carry_chain[i] is the carry enable of stage i
  assign carry_chain[0] = cet;

  for (genvar i = 0; i < N; i++) begin : g_stage
    cascnt_stage u_stage (
      .clk     (clk),
      .clear_n (clear_n),
      .load_n  (load_n),
      .cep     (cep),
      .cet_in  (carry_chain[i]),
      .d       (load_val[i*NIB_W +: NIB_W]),
      .q       (count[i*NIB_W +: NIB_W]),
      .tc_out  (carry_chain[i+1])
    );
  end

  assign tc = carry_chain[N];

  // R6: chained terminal count equals full-width all-ones gated by cet
  p_tc_full_r6: assert property (@(posedge clk) disable iff (!clear_n)
    tc == (cet && (count == {W{1'b1}})));

  // R4: full-width wrap
  p_wrap_r4: assert property (@(posedge clk) disable iff (!clear_n)
    (count == {W{1'b1}} && load_n && cep && cet) |=> count == '0);

  // R7: terminal count low under clear
  always @(posedge clk) begin
    if (!clear_n) p_tc_clear_r7: assert (!tc);
  end
endmodule

// File: tb/cascnt_top_bench.sv
module cascnt_top_bench;
  localparam int N = 2;
  localparam int W = 4 * N;

  logic         clk = 1'b0;
  logic         clear_n = 1'b0;
  logic         load_n = 1'b1;
  logic         cep = 1'b0;
  logic         cet = 1'b0;
  logic [W-1:0] load_val = '0;
  logic [W-1:0] count;
  logic         tc;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;  // 200 MHz

  cascnt_top #(.N(N)) u_cascnt_top (
    .clk(clk), .clear_n(clear_n), .load_n(load_n), .cep(cep), .cet(cet),
    .load_val(load_val), .count(count), .tc(tc)
  );

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // apply inputs at a falling edge, then sample 1 ns after the next rising edge
  task automatic step(input logic ld_n, input logic p, input logic t, input logic [W-1:0] v);
    @(negedge clk);
    load_n = ld_n; cep = p; cet = t; load_val = v;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    clear_n = 1'b0; load_n = 1'b0; cep = 1'b1; cet = 1'b1; load_val = 8'hA5;
    repeat (3) @(posedge clk);
    #1;
    check("R1 count under clear", count, '0);
    check("R7 tc under clear", {7'b0, tc}, '0);
    @(negedge clk); clear_n = 1'b1; load_n = 1'b1; cep = 1'b0; cet = 1'b0;
  endtask

  task automatic t_reference_seq;
    logic [W-1:0] exp_seq [6] = '{8'h0D, 8'h0E, 8'h0F, 8'h10, 8'h11, 8'h12};
    step(1'b0, 1'b0, 1'b0, 8'h0C);
    check("R2 load with enables low", count, 8'h0C);
    for (int k = 0; k < 6; k++) begin
      step(1'b1, 1'b1, 1'b1, 8'h77);
      check("R9 reference count", count, exp_seq[k]);
    end
    step(1'b1, 1'b0, 1'b1, 8'h77);
    check("R5 hold cep low", count, 8'h12);
    step(1'b1, 1'b1, 1'b0, 8'h77);
    check("R5 hold cet low", count, 8'h12);
    check("R9 inhibit keeps nibble at 2", {4'h0, count[3:0]}, 8'h02);
  endtask

  task automatic t_carry_and_wrap;
    step(1'b0, 1'b1, 1'b1, 8'h2F);
    check("R8 load beats count", count, 8'h2F);
    step(1'b1, 1'b1, 1'b1, 8'h00);
    check("R3 nibble carry", count, 8'h30);
    step(1'b0, 1'b0, 1'b0, 8'hFE);
    step(1'b1, 1'b1, 1'b1, 8'h00);
    check("R3 count to all ones", count, 8'hFF);
    check("R6 tc at all ones", {7'b0, tc}, 8'h01);
    @(negedge clk); cep = 1'b0; #1;
    check("R6 tc ignores cep", {7'b0, tc}, 8'h01);
    cet = 1'b0; #1;
    check("R6 tc follows cet without clock", {7'b0, tc}, 8'h00);
    cet = 1'b1; #1;
    check("R6 tc returns with cet", {7'b0, tc}, 8'h01);
    step(1'b1, 1'b1, 1'b1, 8'h00);
    check("R4 wrap to zero", count, 8'h00);
    check("R6 tc low after wrap", {7'b0, tc}, 8'h00);
  endtask

  task automatic t_mid_clear;
    step(1'b0, 1'b0, 1'b1, 8'hFF);
    check("R2 load all ones", count, 8'hFF);
    @(negedge clk); #1;
    load_n = 1'b0; cep = 1'b1; cet = 1'b1; load_val = 8'h5A;
    clear_n = 1'b0; #0.5;
    check("R1 async clear mid cycle", count, 8'h00);
    check("R7 tc low under clear", {7'b0, tc}, 8'h00);
    @(posedge clk); #1;
    check("R8 clear beats load", count, 8'h00);
    @(negedge clk); clear_n = 1'b1;
    @(posedge clk); #1;
    check("R8 load after clear release", count, 8'h5A);
  endtask

  task automatic t_model_compare;
    logic [15:0] lf = 16'hACE1;
    logic [W-1:0] mdl = count;
    for (int k = 0; k < 400; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      @(negedge clk);
      load_n   = ~(lf[2:0] == 3'b000);
      cep      = |lf[4:3];
      cet      = |lf[6:5];
      load_val = lf[15:8] | {4'b0, {4{lf[7]}}};
      if (!load_n)        mdl = load_val;
      else if (cep & cet) mdl = mdl + 1'b1;
      @(posedge clk); #1;
      check("R3 model compare count", count, mdl);
      check("R6 model compare tc", {7'b0, tc}, {7'b0, (cet && mdl == '1)});
    end
  endtask

  initial begin
    t_reset();
    t_reference_seq();
    t_carry_and_wrap();
    t_mid_clear();
    t_model_compare();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #500us;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule